// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Snooped Invalidation

This block is a small fully associative buffer of virtual-to-physical page translations. Each entry carries the identifier of the address space that owns it. Translations from several processes can therefore sit in the buffer together, and a context switch only changes the identifier presented with each lookup. Software installs entries through an explicit fill port, either at a chosen slot or at a slot picked by the block. A hardware table walker is not part of this block.

Entries are removed in three ways:
- A control command clears every entry of one address space.
- A control command clears the whole buffer in a single cycle.
- A snooped bus command from another processor names an address space and a page, and drops that single translation. A page-table edit made elsewhere therefore cannot leave a stale mapping or stale permissions behind.

A lookup is decided combinationally and its result is presented on registered outputs one cycle later.

Top module: `asid_xlate_buf`

## Requirements
- R1: After reset every entry is invalid, the response outputs are zero, and any lookup misses.
- R2: The response for a lookup presented at clock edge N appears on `rsp_valid`, `rsp_hit`, `rsp_pfn` and `rsp_perm` after edge N+1. `rsp_valid` is high only in that cycle. On a miss `rsp_pfn` and `rsp_perm` are zero.
- R3: A lookup hits only if some entry is valid and has both a page number and an address space identifier equal to the request. Entries of different identifiers coexist without any flush.
- R4: `ctl_cmd` = 2'b01 clears the valid bit of exactly the entries whose identifier equals `ctl_asid`. All other entries are left intact.
- R5: `ctl_cmd` = 2'b10 clears every valid bit in one cycle. `ctl_cmd` = 2'b11 is reserved and has no effect, the same as 2'b00.
- R6: A snoop (`snp_valid` high) clears only the entry whose identifier and page number both equal `snp_asid` and `snp_vpn`. A snoop naming the right page under another identifier changes nothing.
- R7: A fill with `fill_auto` low writes page, identifier, frame and permissions at slot `fill_idx` and marks it valid, replacing the previous translation in that slot.
- R8: A fill with `fill_auto` high goes to the lowest-numbered invalid slot. When every slot is valid it goes to a rotating pointer instead. The pointer starts at 0 after reset and advances by one, wrapping, only on evictions it chooses.
- R9: An invalidation or flush that matches either the old or the new contents of a slot being filled in the same cycle wins, and that slot ends invalid.
- R10: A lookup in the same cycle as an invalidation or flush that removes its entry reports a miss.
- R11: When several valid entries match a lookup, the one with the lowest slot number supplies the frame and permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address space of the requester |
| rsp_valid | output | 1 | Registered: a lookup result is present |
| rsp_hit | output | 1 | Registered: the lookup hit |
| rsp_pfn | output | PFN_W | Registered physical frame number, zero on miss |
| rsp_perm | output | PERM_W | Registered permission bits, zero on miss |
| fill_en | input | 1 | Write an entry this cycle |
| fill_auto | input | 1 | 1: slot chosen by the block, 0: slot is `fill_idx` |
| fill_idx | input | IDX_W | Explicit slot for a fill |
| fill_vpn | input | VPN_W | Page number of the new entry |
| fill_asid | input | ASID_W | Address space of the new entry |
| fill_pfn | input | PFN_W | Frame number of the new entry |
| fill_perm | input | PERM_W | Permission bits of the new entry |
| ctl_cmd | input | 2 | 00 idle, 01 flush one address space, 10 flush all, 11 reserved |
| ctl_asid | input | ASID_W | Address space named by a 01 command |
| snp_valid | input | 1 | Snooped invalidate from the bus |
| snp_asid | input | ASID_W | Address space named by the snoop |
| snp_vpn | input | VPN_W | Page named by the snoop |

## Verification
The assertions that check flushes and snoops assume each command lasts one cycle and that its identifier and page are stable during that cycle. They also assume `rst_n` is held for at least one edge before any traffic. The stimulus drives every command for exactly one cycle at the falling edge and clears it at the next falling edge, so these conditions hold throughout. The victim-selection assertion needs no input assumption. The entry contents are built from arithmetic sequences with distinct page numbers per slot, so no lookup is hit accidentally by another slot. The only exception is the duplicate-match case, which is set up on purpose.

// File: rtl/xbuf_pkg.sv
`timescale 1ns/1ps
package xbuf_pkg;
   typedef enum logic [1:0] {
      XB_CMD_IDLE       = 2'b00,
      XB_CMD_FLUSH_ASID = 2'b01,
      XB_CMD_FLUSH_ALL  = 2'b10,
      XB_CMD_RSVD       = 2'b11
   } xb_cmd_e;

   function automatic int unsigned xb_idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/xbuf_victim.sv
`timescale 1ns/1ps
module xbuf_victim #(
   parameter int unsigned ENTRIES        = 16,
   parameter bit          PREFER_INVALID = 1'b1,
   localparam int unsigned IDX_W         = xbuf_pkg::xb_idx_width(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic               adv_i,
   output logic [IDX_W-1:0]   victim_o
);
   logic [IDX_W-1:0] ptr_q;
   logic             use_ptr;

   generate
      if (PREFER_INVALID) begin : g_pref_inv
         logic             any_inv;
         logic [IDX_W-1:0] first_inv;
         always_comb begin
            any_inv   = 1'b0;
            first_inv = '0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
               if (!valid_i[i]) begin
                  any_inv   = 1'b1;
                  first_inv = IDX_W'(i);
               end
            end
         end
         assign use_ptr  = !any_inv;
         assign victim_o = any_inv ? first_inv : ptr_q;

         assert_victim_invalid_R8 : assert property (@(posedge clk) disable iff (!rst_n)
            (adv_i && (valid_i != '1)) |-> !valid_i[victim_o]);
      end else begin : g_pure_rr
         assign use_ptr  = 1'b1;
         assign victim_o = ptr_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv_i && use_ptr) begin
         ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   assert_ptr_range_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= IDX_W'(ENTRIES - 1));
endmodule

// File: rtl/xbuf_tag_store.sv
`timescale 1ns/1ps
module xbuf_tag_store import xbuf_pkg::*; #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ASID_W  = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PFN_W   = 20,
   parameter int unsigned PERM_W  = 4,
   localparam int unsigned IDX_W  = xb_idx_width(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [ASID_W-1:0]  wr_asid,
   input  logic [PFN_W-1:0]   wr_pfn,
   input  logic [PERM_W-1:0]  wr_perm,
   input  xb_cmd_e            cmd,
   input  logic [ASID_W-1:0]  cmd_asid,
   input  logic               snp_valid,
   input  logic [ASID_W-1:0]  snp_asid,
   input  logic [VPN_W-1:0]   snp_vpn,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [ASID_W-1:0]  lk_asid,
   output logic [ENTRIES-1:0] valid_o,
   output logic               any_hit_o,
   output logic [PFN_W-1:0]   hit_pfn_o,
   output logic [PERM_W-1:0]  hit_perm_o
);
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];
   logic [PERM_W-1:0]  perm_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q, valid_d;
   logic [ENTRIES-1:0] kill_old, wr_sel, live_match;
   logic               kill_new;

   // invalidation matches against the stored contents of each slot
   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         kill_old[i] = (cmd == XB_CMD_FLUSH_ALL)
                     | ((cmd == XB_CMD_FLUSH_ASID) && (asid_q[i] == cmd_asid))
                     | (snp_valid && (asid_q[i] == snp_asid) && (vpn_q[i] == snp_vpn));
         wr_sel[i]   = wr_en && (wr_idx == IDX_W'(i));
      end
   end

   // invalidation matches against the contents about to be written
   assign kill_new = (cmd == XB_CMD_FLUSH_ALL)
                   | ((cmd == XB_CMD_FLUSH_ASID) && (wr_asid == cmd_asid))
                   | (snp_valid && (wr_asid == snp_asid) && (wr_vpn == snp_vpn));

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_sel[i]) valid_d[i] = !(kill_old[i] || kill_new);
         else           valid_d[i] = valid_q[i] && !kill_old[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i]  <= '0;
            asid_q[i] <= '0;
            pfn_q[i]  <= '0;
            perm_q[i] <= '0;
         end
      end else begin
         valid_q <= valid_d;
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_sel[i]) begin
               vpn_q[i]  <= wr_vpn;
               asid_q[i] <= wr_asid;
               pfn_q[i]  <= wr_pfn;
               perm_q[i] <= wr_perm;
            end
         end
      end
   end

   // lookup: an entry being invalidated this cycle no longer counts
   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         live_match[i] = valid_q[i] && !kill_old[i]
                       && (vpn_q[i] == lk_vpn) && (asid_q[i] == lk_asid);
      end
   end

   always_comb begin
      any_hit_o  = 1'b0;
      hit_pfn_o  = '0;
      hit_perm_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (live_match[i]) begin
            any_hit_o  = 1'b1;
            hit_pfn_o  = pfn_q[i];
            hit_perm_o = perm_q[i];
         end
      end
   end

   assign valid_o = valid_q;

   // checker state: remember the last flush / snoop target
   logic               fa_pend, sn_pend;
   logic [ASID_W-1:0]  fa_tag, sn_asid;
   logic [VPN_W-1:0]   sn_vpn;
   logic [ENTRIES-1:0] fa_left, sn_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fa_pend <= 1'b0;
         fa_tag  <= '0;
         sn_pend <= 1'b0;
         sn_asid <= '0;
         sn_vpn  <= '0;
      end else begin
         fa_pend <= (cmd == XB_CMD_FLUSH_ASID);
         fa_tag  <= cmd_asid;
         sn_pend <= snp_valid;
         sn_asid <= snp_asid;
         sn_vpn  <= snp_vpn;
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         fa_left[i] = valid_q[i] && (asid_q[i] == fa_tag);
         sn_left[i] = valid_q[i] && (asid_q[i] == sn_asid) && (vpn_q[i] == sn_vpn);
      end
   end

   assert_flush_asid_clean_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      fa_pend |-> (fa_left == '0));
   assert_flush_all_clean_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == XB_CMD_FLUSH_ALL) |=> (valid_q == '0));
   assert_snoop_clean_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      sn_pend |-> (sn_left == '0));
   assert_fill_lands_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (cmd == XB_CMD_IDLE) && !snp_valid) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/asid_xlate_buf.sv
`timescale 1ns/1ps
module asid_xlate_buf import xbuf_pkg::*; #(
   parameter int unsigned ENTRIES        = 16,
   parameter int unsigned ASID_W         = 8,
   parameter int unsigned VPN_W          = 20,
   parameter int unsigned PFN_W          = 20,
   parameter int unsigned PERM_W         = 4,
   parameter bit          PREFER_INVALID = 1'b1,
   localparam int unsigned IDX_W         = xb_idx_width(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [PERM_W-1:0] rsp_perm,
   input  logic              fill_en,
   input  logic              fill_auto,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic [1:0]        ctl_cmd,
   input  logic [ASID_W-1:0] ctl_asid,
   input  logic              snp_valid,
   input  logic [ASID_W-1:0] snp_asid,
   input  logic [VPN_W-1:0]  snp_vpn
);
   generate
      if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
         $error("asid_xlate_buf: ENTRIES out of range");
      end
      if (ASID_W < 1 || VPN_W < 1 || PFN_W < 1 || PERM_W < 1) begin : g_bad_width
         $error("asid_xlate_buf: field widths must be positive");
      end
   endgenerate

   xb_cmd_e            cmd;
   logic [ENTRIES-1:0] valid_vec;
   logic [IDX_W-1:0]   victim, wr_idx;
   logic               any_hit;
   logic [PFN_W-1:0]   hit_pfn;
   logic [PERM_W-1:0]  hit_perm;

   assign cmd    = xb_cmd_e'(ctl_cmd);
   assign wr_idx = fill_auto ? victim : fill_idx;

   xbuf_victim #(
      .ENTRIES        (ENTRIES),
      .PREFER_INVALID (PREFER_INVALID)
   ) victim_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (valid_vec),
      .adv_i    (fill_en && fill_auto),
      .victim_o (victim)
   );

   xbuf_tag_store #(
      .ENTRIES (ENTRIES),
      .ASID_W  (ASID_W),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .PERM_W  (PERM_W)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (fill_en),
      .wr_idx     (wr_idx),
      .wr_vpn     (fill_vpn),
      .wr_asid    (fill_asid),
      .wr_pfn     (fill_pfn),
      .wr_perm    (fill_perm),
      .cmd        (cmd),
      .cmd_asid   (ctl_asid),
      .snp_valid  (snp_valid),
      .snp_asid   (snp_asid),
      .snp_vpn    (snp_vpn),
      .lk_vpn     (lk_vpn),
      .lk_asid    (lk_asid),
      .valid_o    (valid_vec),
      .any_hit_o  (any_hit),
      .hit_pfn_o  (hit_pfn),
      .hit_perm_o (hit_perm)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_pfn   <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && any_hit;
         rsp_pfn   <= (lk_valid && any_hit) ? hit_pfn  : '0;
         rsp_perm  <= (lk_valid && any_hit) ? hit_perm : '0;
      end
   end

   assert_hit_needs_request_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit);
   assert_miss_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> ((rsp_pfn == '0) && (rsp_perm == '0)));
   assert_flush_beats_lookup_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && (ctl_cmd == 2'b10)) |=> !rsp_hit);
   assert_empty_misses_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && (valid_vec == '0)) |=> !rsp_hit);
endmodule

// File: tb/asid_xlate_buf_tb_top.sv
`timescale 1ns/1ps
module asid_xlate_buf_tb_top;
   localparam int unsigned ENT = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid, fill_en, fill_auto, snp_valid;
   logic [19:0] lk_vpn, fill_vpn, snp_vpn, fill_pfn;
   logic [7:0]  lk_asid, fill_asid, ctl_asid, snp_asid;
   logic [3:0]  fill_idx, fill_perm;
   logic [1:0]  ctl_cmd;
   logic        rsp_valid, rsp_hit;
   logic [19:0] rsp_pfn;
   logic [3:0]  rsp_perm;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   asid_xlate_buf dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
      .fill_en(fill_en), .fill_auto(fill_auto), .fill_idx(fill_idx),
      .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
      .ctl_cmd(ctl_cmd), .ctl_asid(ctl_asid),
      .snp_valid(snp_valid), .snp_asid(snp_asid), .snp_vpn(snp_vpn)
   );

   function automatic logic [19:0] vpn_of(input int i); return 20'(i * 3 + 5);   endfunction
   function automatic logic [7:0]  asid_of(input int i); return 8'(i % 4);      endfunction
   function automatic logic [19:0] pfn_of(input int i); return 20'(i * 7 + 100); endfunction
   function automatic logic [3:0]  perm_of(input int i); return 4'((i * 5) % 16); endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic look(input logic [19:0] v, input logic [7:0] a, input bit eh,
                       input logic [19:0] ep, input logic [3:0] eperm, input string req);
      lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
      @(negedge clk);
      lk_valid = 1'b0;
      chk({req, " valid/hit"}, {30'd0, rsp_valid, rsp_hit}, {30'd0, 1'b1, eh});
      chk({req, " pfn"},  {12'd0, rsp_pfn},  eh ? {12'd0, ep} : 32'd0);
      chk({req, " perm"}, {28'd0, rsp_perm}, eh ? {28'd0, eperm} : 32'd0);
   endtask

   task automatic set_fill(input bit au, input int idx, input logic [19:0] v,
                           input logic [7:0] a, input logic [19:0] p, input logic [3:0] pm);
      fill_en = 1'b1; fill_auto = au; fill_idx = 4'(idx);
      fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm;
   endtask

   task automatic fill(input bit au, input int idx, input logic [19:0] v,
                       input logic [7:0] a, input logic [19:0] p, input logic [3:0] pm);
      set_fill(au, idx, v, a, p, pm);
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic command(input logic [1:0] c, input logic [7:0] a);
      ctl_cmd = c; ctl_asid = a;
      @(negedge clk);
      ctl_cmd = 2'b00;
   endtask

   task automatic snoop(input logic [7:0] a, input logic [19:0] v);
      snp_valid = 1'b1; snp_asid = a; snp_vpn = v;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   initial begin
      #(4ns * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; lk_valid = 0; fill_en = 0; fill_auto = 0; snp_valid = 0;
      lk_vpn = 0; lk_asid = 0; fill_vpn = 0; fill_asid = 0; fill_pfn = 0;
      fill_perm = 0; fill_idx = 0; ctl_cmd = 0; ctl_asid = 0; snp_asid = 0; snp_vpn = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state and lookup of all-zero tags misses
      chk("R1 rsp after reset", {rsp_valid, rsp_hit, 30'(rsp_pfn)}, 32'd0);
      look(20'd0, 8'd0, 1'b0, 20'd0, 4'd0, "R1 empty lookup");
      @(negedge clk);
      chk("R2 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);

      // R7: explicit fill of every slot
      for (int i = 0; i < ENT; i++) fill(1'b0, i, vpn_of(i), asid_of(i), pfn_of(i), perm_of(i));
      // R3: sweep every slot against every identifier
      for (int i = 0; i < ENT; i++)
         for (int a = 0; a < 4; a++)
            look(vpn_of(i), 8'(a), (a == i % 4), pfn_of(i), perm_of(i), "R3 sweep");

      // R4: flush identifier 2
      command(2'b01, 8'd2);
      for (int i = 0; i < ENT; i++)
         look(vpn_of(i), asid_of(i), (i % 4 != 2), pfn_of(i), perm_of(i), "R4 flush asid");

      // R6: wrong identifier leaves slot 5; right one removes only slot 5
      snoop(8'd0, vpn_of(5));
      look(vpn_of(5), asid_of(5), 1'b1, pfn_of(5), perm_of(5), "R6 wrong asid");
      snoop(8'd1, vpn_of(5));
      look(vpn_of(5), asid_of(5), 1'b0, 20'd0, 4'd0, "R6 snooped slot");
      look(vpn_of(9), asid_of(9), 1'b1, pfn_of(9), perm_of(9), "R6 neighbour");

      // R10: lookup racing a snoop and a flush of its entry
      snp_valid = 1'b1; snp_asid = asid_of(13); snp_vpn = vpn_of(13);
      look(vpn_of(13), asid_of(13), 1'b0, 20'd0, 4'd0, "R10 race snoop");
      snp_valid = 1'b0;
      ctl_cmd = 2'b01; ctl_asid = 8'd0;
      look(vpn_of(0), 8'd0, 1'b0, 20'd0, 4'd0, "R10 race flush");
      ctl_cmd = 2'b00;
      look(vpn_of(4), 8'd0, 1'b0, 20'd0, 4'd0, "R4 flush asid 0");

      // R5: reserved command is a no-op, then flush all
      command(2'b11, 8'd1);
      look(vpn_of(1), asid_of(1), 1'b1, pfn_of(1), perm_of(1), "R5 reserved cmd");
      command(2'b10, 8'd0);
      for (int i = 0; i < ENT; i++)
         look(vpn_of(i), asid_of(i), 1'b0, 20'd0, 4'd0, "R5 flush all");

      // R9: fill colliding with invalidation
      set_fill(1'b0, 3, 20'd800, 8'd5, 20'h3, 4'd1); ctl_cmd = 2'b10;
      @(negedge clk); fill_en = 0; ctl_cmd = 2'b00;
      look(20'd800, 8'd5, 1'b0, 20'd0, 4'd0, "R9 fill vs flush all");
      set_fill(1'b0, 7, 20'd810, 8'd5, 20'h7, 4'd1);
      snp_valid = 1'b1; snp_asid = 8'd5; snp_vpn = 20'd810;
      @(negedge clk); fill_en = 0; snp_valid = 0;
      look(20'd810, 8'd5, 1'b0, 20'd0, 4'd0, "R9 fill vs snoop new");
      fill(1'b0, 8, 20'd820, 8'd6, 20'h8, 4'd2);
      set_fill(1'b0, 8, 20'd830, 8'd6, 20'h9, 4'd2);
      snp_valid = 1'b1; snp_asid = 8'd6; snp_vpn = 20'd820;
      @(negedge clk); fill_en = 0; snp_valid = 0;
      look(20'd830, 8'd6, 1'b0, 20'd0, 4'd0, "R9 fill vs snoop old");
      command(2'b10, 8'd0);

      // R8: invalid slots first, then rotating pointer
      for (int k = 0; k < ENT; k++) fill(1'b1, 0, 20'(200 + k), 8'd7, 20'(1000 + k), 4'(k));
      for (int k = 0; k < ENT; k++) look(20'(200 + k), 8'd7, 1'b1, 20'(1000 + k), 4'(k), "R8 auto fill");
      fill(1'b1, 0, 20'd300, 8'd7, 20'd2000, 4'd9);
      look(20'd200, 8'd7, 1'b0, 20'd0, 4'd0, "R8 ptr evicts slot 0");
      look(20'd300, 8'd7, 1'b1, 20'd2000, 4'd9, "R8 new at slot 0");
      fill(1'b1, 0, 20'd301, 8'd7, 20'd2001, 4'd9);
      look(20'd201, 8'd7, 1'b0, 20'd0, 4'd0, "R8 ptr evicts slot 1");
      snoop(8'd7, 20'd205);
      fill(1'b1, 0, 20'd400, 8'd7, 20'd2400, 4'd3);
      look(20'd400, 8'd7, 1'b1, 20'd2400, 4'd3, "R8 hole refilled");
      look(20'd202, 8'd7, 1'b1, 20'd1002, 4'd2, "R8 ptr held");
      fill(1'b1, 0, 20'd401, 8'd7, 20'd2401, 4'd3);
      look(20'd202, 8'd7, 1'b0, 20'd0, 4'd0, "R8 ptr evicts slot 2");
      look(20'd203, 8'd7, 1'b1, 20'd1003, 4'd3, "R8 slot 3 kept");
      fill(1'b0, 3, 20'd500, 8'd7, 20'd2500, 4'd5);
      look(20'd203, 8'd7, 1'b0, 20'd0, 4'd0, "R7 overwrite slot 3");
      look(20'd500, 8'd7, 1'b1, 20'd2500, 4'd5, "R7 new slot 3");

      // R11: duplicate translations, lowest slot wins
      command(2'b10, 8'd0);
      fill(1'b0, 6, 20'd900, 8'd2, 20'h66, 4'd6);
      fill(1'b0, 1, 20'd900, 8'd2, 20'h11, 4'd1);
      look(20'd900, 8'd2, 1'b1, 20'h11, 4'd1, "R11 lowest slot");
      snoop(8'd2, 20'd900);
      look(20'd900, 8'd2, 1'b0, 20'd0, 4'd0, "R6 duplicates removed");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule